// File: doc/BRIEF.md
# One-Shot Pulse Unit with Gated Early Termination

This block runs a set of independent one-shot pulse channels (sixteen by default). Each channel owns a loadable down-counter and a run bit. When software sets the run bit while the counter is nonzero, the channel's pulse output goes high. It stays high while the counter counts down by one each clock.

A pulse ends in one of two ways. In the first, the counter runs out on its own. In the second, an external trigger cuts the pulse short, but only if that channel's bit in a software-written enable register is set. Either way the run bit and the counter go to zero and the channel's completion flag sets.

The triggers come from two neighbouring timers, each with one line per compare event. The lower half of the channels listens to the first timer and the upper half to the second. Software reaches every register over a flat write/read bus.

Top module: `osp_term_unit`

## Requirements
- R1: The termination-enable register sits at address 0. It is read and written as a whole word, bit n governs channel n, and it is zero after reset.
- R2: While `standby_i` is high at a clock edge, the termination-enable register is cleared to zero.
- R3: Writing address 1 with bit n set, while channel n is idle with a nonzero counter value N, drives `pulse_o[n]` high for exactly N clock cycles, starting in the cycle after the write. Address 1 reads back the run bits.
- R4: On natural expiry the pulse drops, the run bit clears, the counter reads 0 and status bit n sets.
- R5: While channel n runs with its enable bit set, a trigger ends the pulse at the next edge: the output goes low, the counter reads 0 and status bit n sets.
- R6: A trigger has no effect on a channel whose enable bit is 0, or on an idle channel. The counter keeps counting or holds its value, and no status bit sets.
- R7: Channels 0 to NCH/2-1 are ended by `trig_lo_i` bit n. Channel NCH/2+k is ended by `trig_hi_i` bit k, so the top channel listens to the highest bit of the second timer.
- R8: Status sits at address 2. Writing 1 to a bit clears it and writing 0 has no effect. If a set and a clear hit the same bit at one edge, the bit stays set.
- R9: If a trigger and natural expiry coincide, the channel ends once, with the counter at 0 and only its own status bit set.
- R10: Address 16+n loads channel n's counter from the low data bits, but only while that channel is idle. Writes during a pulse are dropped. The address reads the live counter.
- R11: A start request for a channel whose counter is 0 is ignored: the run bit and the output stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby_i | input | 1 | Standby entry, clears the enable register |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | AW | Register address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data for `bus_addr_i` (combinational) |
| trig_lo_i | input | NCH/2 | Terminate triggers from the first timer |
| trig_hi_i | input | NCH/2 | Terminate triggers from the second timer |
| pulse_o | output | NCH | Per-channel one-shot outputs |

## Verification
Pulse length is swept over every channel, with counter values that run from 1 up to the counter's maximum. This separates an off-by-one in the countdown from a wrong channel decode.

Early termination is tried on each channel while its partner in the other half also runs and is enabled. Only the addressed channel may stop, which exposes crossed trigger routing.

Further patterns cover:
- a trigger on a disabled channel and on an idle channel;
- a trigger landing exactly on the expiry edge;
- a status clear landing on the set edge;
- a counter reload during a pulse;
- a start request with a zero counter.

Each of these tells a correct gate apart from one that is missing or inverted.

// File: rtl/osp_pkg.sv
package osp_pkg;
   // register address map (word addresses)
   localparam int ADDR_ENABLE = 0;
   localparam int ADDR_START  = 1;
   localparam int ADDR_STATUS = 2;
   localparam int ADDR_COUNT  = 16;

   // minimum address width needed to reach every counter register
   function automatic int min_addr_bits(input int nch);
      int top;
      int bits;
      top  = ADDR_COUNT + nch - 1;
      bits = 1;
      while ((1 << bits) <= top) bits++;
      return bits;
   endfunction
endpackage

// File: rtl/osp_channel.sv
module osp_channel #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   input  logic          start_i,
   input  logic          term_en_i,
   input  logic          trig_i,
   output logic          run_o,
   output logic [CW-1:0] cnt_o,
   output logic          done_o
);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic          run_q;
   logic [CW-1:0] cnt_q;
   logic          expire;
   logic          force_end;

   assign expire    = run_q && (cnt_q == ONE);
   assign force_end = run_q && term_en_i && trig_i;
   assign done_o    = expire || force_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (done_o) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (run_q) begin
         cnt_q <= cnt_q - ONE;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (start_i && (cnt_q != '0)) begin
         run_q <= 1'b1;
      end
   end

   assign run_o = run_q;
   assign cnt_o = cnt_q;
endmodule

// File: rtl/osp_trig_map.sv
module osp_trig_map #(
   parameter int HALF = 8
) (
   input  logic [HALF-1:0]   lo_i,
   input  logic [HALF-1:0]   hi_i,
   output logic [2*HALF-1:0] ch_o
);
   for (genvar g = 0; g < HALF; g++) begin : g_map
      assign ch_o[g]        = lo_i[g];
      assign ch_o[g + HALF] = hi_i[g];
   end
endmodule

// File: rtl/osp_readmux.sv
module osp_readmux
   import osp_pkg::*;
#(
   parameter int NCH = 16,
   parameter int CW  = 16,
   parameter int DW  = 16,
   parameter int AW  = 6
) (
   input  logic [AW-1:0]     addr_i,
   input  logic [NCH-1:0]    en_i,
   input  logic [NCH-1:0]    run_i,
   input  logic [NCH-1:0]    stat_i,
   input  logic [NCH*CW-1:0] cnt_i,
   output logic [DW-1:0]     rdata_o
);
   always_comb begin
      rdata_o = '0;
      if (addr_i == AW'(ADDR_ENABLE)) rdata_o[NCH-1:0] = en_i;
      if (addr_i == AW'(ADDR_START))  rdata_o[NCH-1:0] = run_i;
      if (addr_i == AW'(ADDR_STATUS)) rdata_o[NCH-1:0] = stat_i;
      for (int i = 0; i < NCH; i++) begin
         if (addr_i == AW'(ADDR_COUNT + i)) rdata_o[CW-1:0] = cnt_i[i*CW +: CW];
      end
   end
endmodule

// File: rtl/osp_term_unit.sv
module osp_term_unit
   import osp_pkg::*;
#(
   parameter int NCH = 16,
   parameter int CW  = 16,
   parameter int DW  = 16,
   parameter int AW  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             standby_i,
   input  logic             bus_wr_i,
   input  logic [AW-1:0]    bus_addr_i,
   input  logic [DW-1:0]    bus_wdata_i,
   output logic [DW-1:0]    bus_rdata_o,
   input  logic [NCH/2-1:0] trig_lo_i,
   input  logic [NCH/2-1:0] trig_hi_i,
   output logic [NCH-1:0]   pulse_o
);
   localparam int HALF = NCH / 2;

   // elaboration-time parameter checks
   if ((NCH < 2) || (NCH % 2 != 0)) begin : g_bad_nch
      $error("NCH must be even and at least 2");
   end
   if ((DW < NCH) || (DW < CW)) begin : g_bad_dw
      $error("DW must cover both NCH and CW");
   end
   if (AW < min_addr_bits(NCH)) begin : g_bad_aw
      $error("AW too narrow for the counter registers");
   end

   logic              wr_enable, wr_start, wr_status;
   logic [NCH-1:0]    en_q;
   logic [NCH-1:0]    status_q;
   logic [NCH-1:0]    run;
   logic [NCH-1:0]    done;
   logic [NCH-1:0]    trig_ch;
   logic [NCH*CW-1:0] cnt_flat;
   logic [NCH-1:0]    clr_mask;

   assign wr_enable = bus_wr_i && (bus_addr_i == AW'(ADDR_ENABLE));
   assign wr_start  = bus_wr_i && (bus_addr_i == AW'(ADDR_START));
   assign wr_status = bus_wr_i && (bus_addr_i == AW'(ADDR_STATUS));
   assign clr_mask  = wr_status ? bus_wdata_i[NCH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= '0;
      else if (standby_i) en_q <= '0;
      else if (wr_enable) en_q <= bus_wdata_i[NCH-1:0];
   end

   // a set event wins over a clear written in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~clr_mask) | done;
   end

   osp_trig_map #(.HALF(HALF)) u_map (
      .lo_i (trig_lo_i),
      .hi_i (trig_hi_i),
      .ch_o (trig_ch)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic ld;
      assign ld = bus_wr_i && (bus_addr_i == AW'(ADDR_COUNT + n));
      osp_channel #(.CW(CW)) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .load_i     (ld),
         .load_val_i (bus_wdata_i[CW-1:0]),
         .start_i    (wr_start && bus_wdata_i[n]),
         .term_en_i  (en_q[n]),
         .trig_i     (trig_ch[n]),
         .run_o      (run[n]),
         .cnt_o      (cnt_flat[n*CW +: CW]),
         .done_o     (done[n])
      );
   end

   osp_readmux #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) u_rd (
      .addr_i  (bus_addr_i),
      .en_i    (en_q),
      .run_i   (run),
      .stat_i  (status_q),
      .cnt_i   (cnt_flat),
      .rdata_o (bus_rdata_o)
   );

   assign pulse_o = run;
endmodule

// File: rtl/osp_term_unit_chk.sv
module osp_term_unit_chk
   import osp_pkg::*;
#(
   parameter int NCH = 16,
   parameter int DW  = 16,
   parameter int AW  = 6
) (
   input logic           clk,
   input logic           rst_n,
   input logic           standby_i,
   input logic           bus_wr_i,
   input logic [AW-1:0]  bus_addr_i,
   input logic [DW-1:0]  bus_wdata_i,
   input logic [NCH-1:0] pulse_o,
   input logic [NCH-1:0] en_q,
   input logic [NCH-1:0] status_q
);
   // R1: an enable write outside standby lands in the register
   a_r1_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == AW'(ADDR_ENABLE) && !standby_i)
      |=> en_q == $past(bus_wdata_i[NCH-1:0]));

   // R2: standby clears the enable register
   a_r2_standby_clear: assert property (@(posedge clk) disable iff (!rst_n)
      standby_i |=> en_q == '0);

   // R3: a pulse only rises after a write to the start address
   a_r3_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pulse_o & ~$past(pulse_o)))
      |-> $past(bus_wr_i && bus_addr_i == AW'(ADDR_START)));

   // R4 / R5: every pulse end leaves its status bit set
   a_r4_end_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pulse_o) & ~pulse_o & ~status_q) == '0);

   // R8: a write-one clear removes the bit unless it was set at that edge
   a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_wr_i && bus_addr_i == AW'(ADDR_STATUS))
      |-> (status_q & $past(bus_wdata_i[NCH-1:0]) & ~($past(pulse_o) & ~pulse_o)) == '0);
endmodule

bind osp_term_unit osp_term_unit_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .standby_i   (standby_i),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .pulse_o     (pulse_o),
   .en_q        (en_q),
   .status_q    (status_q)
);

// File: tb/osp_term_unit_test.sv
module osp_term_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 16;
   localparam int CW  = 8;
   localparam int DW  = 16;
   localparam int AW  = 6;
   localparam int A_EN = 0, A_RUN = 1, A_ST = 2, A_CNT = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            standby = 1'b0;
   logic            bus_wr = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic [DW-1:0]   bus_wdata = '0;
   logic [DW-1:0]   bus_rdata;
   logic [NCH/2-1:0] trig_lo = '0;
   logic [NCH/2-1:0] trig_hi = '0;
   logic [NCH-1:0]  pulse;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 0;

   osp_term_unit #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .standby_i(standby),
      .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
      .bus_rdata_o(bus_rdata), .trig_lo_i(trig_lo), .trig_hi_i(trig_hi),
      .pulse_o(pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [DW-1:0] d);
      bus_addr = AW'(a);
      #1;
      d = bus_rdata;
   endtask

   // drive one channel's trigger line across exactly one rising edge
   task automatic fire(input int ch);
      if (ch < NCH/2) trig_lo[ch] = 1'b1;
      else            trig_hi[ch - NCH/2] = 1'b1;
      @(negedge clk);
      trig_lo = '0; trig_hi = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(A_EN, v);  check("R1 reset enable", v, 0);
      rd(A_RUN, v); check("R3 reset run", v, 0);
      rd(A_ST, v);  check("R8 reset status", v, 0);
      check("R3 reset pulse", pulse, 0);

      // R1: enable register read/write
      wr(A_EN, 16'hA5C3); rd(A_EN, v); check("R1 enable rw", v, 16'hA5C3);
      // R2: standby clears it
      @(negedge clk); standby = 1'b1; @(negedge clk); standby = 1'b0;
      rd(A_EN, v); check("R2 standby clear", v, 0);

      // R3 / R4: pulse length sweep over every channel
      for (int c = 0; c < NCH; c++) begin
         int len;
         int h;
         len = (c == 0) ? 1 : (c == 1) ? 255 : ((c * 37) % 250) + 2;
         wr(A_CNT + c, DW'(len));
         wr(A_RUN, DW'(1) << c);
         h = 0;
         while (pulse[c] === 1'b1 && h < 400) begin
            h++;
            @(negedge clk);
         end
         check($sformatf("R3 length ch%0d", c), h, len);
         rd(A_CNT + c, v); check("R4 counter zero", v, 0);
         rd(A_ST, v);      check("R4 status set", v, DW'(1) << c);
         rd(A_RUN, v);     check("R4 run clear", v, 0);
         wr(A_ST, DW'(1) << c);
         rd(A_ST, v);      check("R8 w1c", v, 0);
      end

      // R5 / R7: forced end with the partner in the other half also running
      wr(A_EN, 16'hFFFF);
      for (int c = 0; c < NCH; c++) begin
         int p;
         p = c ^ (NCH/2);
         wr(A_CNT + c, 40);
         wr(A_CNT + p, 40);
         wr(A_RUN, (DW'(1) << c) | (DW'(1) << p));
         @(negedge clk);
         fire(c);
         check($sformatf("R5 stop ch%0d", c), pulse[c], 0);
         check($sformatf("R7 partner ch%0d runs", p), pulse[p], 1);
         rd(A_CNT + c, v); check("R5 counter zero", v, 0);
         rd(A_ST, v);      check("R7 only own flag", v, DW'(1) << c);
         fire(p);
         check("R7 partner stop", pulse[p], 0);
         wr(A_ST, 16'hFFFF);
      end

      // R6: disabled channel ignores trigger
      wr(A_EN, 16'hFFF7);
      wr(A_CNT + 3, 30);
      wr(A_RUN, DW'(1) << 3);
      @(negedge clk);
      fire(3);
      check("R6 disabled keeps pulse", pulse[3], 1);
      rd(A_CNT + 3, v); check("R6 disabled keeps counting", v, 28);
      rd(A_ST, v);      check("R6 disabled no flag", v, 0);
      wr(A_EN, 16'hFFFF);
      fire(3);
      wr(A_ST, 16'hFFFF);

      // R6: idle channel ignores trigger
      wr(A_CNT + 5, 7);
      fire(5);
      rd(A_CNT + 5, v); check("R6 idle counter held", v, 7);
      rd(A_ST, v);      check("R6 idle no flag", v, 0);
      check("R6 idle pulse low", pulse[5], 0);

      // R11: start with zero counter is ignored
      wr(A_RUN, DW'(1) << 6);
      check("R11 zero start pulse", pulse[6], 0);
      rd(A_RUN, v); check("R11 zero start run", v, 0);

      // R10: reload during a pulse is dropped
      wr(A_CNT + 2, 20);
      wr(A_RUN, DW'(1) << 2);
      wr(A_CNT + 2, 100);
      rd(A_CNT + 2, v); check("R10 reload ignored", v, 18);
      fire(2);
      wr(A_ST, 16'hFFFF);

      // R9: trigger on the expiry edge
      wr(A_CNT + 4, 3);
      wr(A_RUN, DW'(1) << 4);
      @(negedge clk);
      @(negedge clk);
      fire(4);
      check("R9 pulse low", pulse[4], 0);
      rd(A_CNT + 4, v); check("R9 counter zero", v, 0);
      rd(A_ST, v);      check("R9 single flag", v, DW'(1) << 4);
      wr(A_ST, 16'hFFFF);

      // R8: set wins over a same-edge clear
      wr(A_CNT + 1, 2);
      wr(A_RUN, DW'(1) << 1);
      wr(A_ST, DW'(1) << 1);
      check("R8 pulse ended", pulse[1], 0);
      rd(A_ST, v); check("R8 set wins", v, DW'(1) << 1);
      wr(A_ST, 16'h0000);
      rd(A_ST, v); check("R8 zero write no effect", v, DW'(1) << 1);

      finish_run();
   end
endmodule